// File: doc/BRIEF.md
# Clock Fanout Output Gating Controller

This block is the digital control of a five-output differential clock fanout buffer. A single reference clock is copied to five true/complement output pairs. Each pair runs only when the device has been started by a power-good signal, a per-output configuration bit allows it and its own active-low enable pin is driven low. A stopped pair is parked with both legs low, not held at opposite levels.

The power-good input also selects the device's seven-bit bus address. That address is captured once, from a tri-level select strap that has already been decoded to two bits, at the first rising edge of power-good after the asynchronous reset. Once the device has started, dropping power-good puts it into power-down, with every pair low on both legs. Raising power-good again brings it out, and the address is not sampled a second time. All control inputs are synchronised to the reference clock. The gate of each pair changes only while the reference clock is low, so no output ever emits a shortened high pulse.

Top module: `clkFanoutGate`

## Requirements
- R1: From reset until the first rising edge of `pwrGood`, all ten output legs stay low and `busAddr` reads 0, whatever the enable pins, enable bits and select input do.
- R2: At the first rising edge of `pwrGood`, `addrSel` is captured and drives `busAddr`. The mapping is 2'b00 (low) → 7'b1101011, 2'b01 (mid) → 7'b1101100, 2'b10 (high) → 7'b1101101, and 2'b11 → 7'b1101100, the same as mid.
- R3: After start-up, `pwrGood` low puts every pair in power-down with both legs low. A later `pwrGood` high makes the enabled pairs run again.
- R4: Later rising edges of `pwrGood`, and any change of `addrSel` after start-up, leave `busAddr` unchanged until the next reset.
- R5: Pair i runs when powered and started, enable bit i is 1 and `enPinN[i]` is 0. Bit i of the expected running mask is `cfg[i] & ~enPinN[i]`.
- R6: Pair i has both legs low when enable bit i is 0, whatever its pin is. It also has both legs low when the bit is 1 and the pin is 1.
- R7: A running pair drives `outTrue[i]` equal to `refClk` and `outComp[i]` equal to its inverse.
- R8: The five enable bits reset to 1. A write with `cfgWe` high loads `cfgData`, bit i for pair i, at a rising `refClk` edge.
- R9: An output leg `outTrue[i]` rises only together with a rising `refClk` and falls only together with a falling `refClk`. This holds across all enable, disable and power-down transitions, so no runt pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Reference clock copied to the outputs |
| rstN | input | 1 | Asynchronous active-low device reset |
| pwrGood | input | 1 | Power-good / power-down control, asynchronous |
| addrSel | input | 2 | Decoded tri-level address strap: 00 low, 01 mid, 10 high |
| enPinN | input | 5 | Active-low per-output enable pins |
| cfgWe | input | 1 | Write strobe for the enable-bit register |
| cfgData | input | 5 | New value for the enable bits |
| outTrue | output | 5 | True leg of each output pair |
| outComp | output | 5 | Complement leg of each output pair |
| busAddr | output | 7 | Latched seven-bit bus address |

## Verification
The bench starts the device once for each select code and then moves `addrSel` and toggles `pwrGood`. A design that re-sampled the strap on every assertion would show a new address at that point. It sweeps all 1024 combinations of enable bits and enable pins and checks both legs in both clock phases. Treating a disabled pair as complementary, or letting the pin override a cleared bit, would show up as a wrong leg level. A monitor watches every edge of every true leg: a gate that switched while the clock was high would make a leg fall while `refClk` is still high, which the monitor flags as a runt. Outputs are also checked before start-up and during power-down, which catches a design that runs before its first power-good edge or ignores power-down.

// File: rtl/clkfan_pkg.sv
package clkfan_pkg;
  localparam int OUT_COUNT   = 5;
  localparam int ADDR_W      = 7;
  localparam int SYNC_STAGES = 2;

  localparam logic [1:0] SEL_LOW  = 2'b00;
  localparam logic [1:0] SEL_MID  = 2'b01;
  localparam logic [1:0] SEL_HIGH = 2'b10;

  localparam logic [ADDR_W-1:0] ADDR_AT_LOW  = 7'b1101011;
  localparam logic [ADDR_W-1:0] ADDR_AT_MID  = 7'b1101100;
  localparam logic [ADDR_W-1:0] ADDR_AT_HIGH = 7'b1101101;

  // Strobes from control to datapath
  typedef struct packed {
    logic                 active;
    logic [OUT_COUNT-1:0] runReq;
  } gateStrb_t;

  function automatic logic [ADDR_W-1:0] decodeAddr(input logic [1:0] sel);
    case (sel)
      SEL_LOW:  decodeAddr = ADDR_AT_LOW;
      SEL_HIGH: decodeAddr = ADDR_AT_HIGH;
      default:  decodeAddr = ADDR_AT_MID;
    endcase
  endfunction
endpackage

// File: rtl/clkFanCtrl.sv
module clkFanCtrl
  import clkfan_pkg::*;
#(
  parameter int NumOut     = OUT_COUNT,
  parameter int SyncStages = SYNC_STAGES,
  parameter int AddrW      = ADDR_W
) (
  input  logic              refClk,
  input  logic              rstN,
  input  logic              pwrGood,
  input  logic [1:0]        addrSel,
  input  logic [NumOut-1:0] enPinN,
  input  logic              cfgWe,
  input  logic [NumOut-1:0] cfgData,
  output gateStrb_t         strb,
  output logic [AddrW-1:0]  busAddr
);
  localparam int LastStage = SyncStages - 1;

  logic [NumOut-1:0] enRegQ;
  logic [NumOut-1:0] reqRaw;
  logic [SyncStages-1:0] pgSyncQ;
  logic [NumOut-1:0] reqSyncQ [SyncStages];
  logic pgSync, pgPrev, pgRise, started;

  // Enable-bit register, resets to all enabled
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) enRegQ <= '1;
    else if (cfgWe) enRegQ <= cfgData;
  end

  assign reqRaw = enRegQ & ~enPinN;

  // Synchronisers for power-good and the per-output requests
  genvar s;
  generate
    for (s = 0; s < SyncStages; s++) begin : gSync
      if (s == 0) begin : gFirst
        always_ff @(posedge refClk or negedge rstN) begin
          if (!rstN) begin
            pgSyncQ[0]  <= 1'b0;
            reqSyncQ[0] <= '0;
          end else begin
            pgSyncQ[0]  <= pwrGood;
            reqSyncQ[0] <= reqRaw;
          end
        end
      end else begin : gNext
        always_ff @(posedge refClk or negedge rstN) begin
          if (!rstN) begin
            pgSyncQ[s]  <= 1'b0;
            reqSyncQ[s] <= '0;
          end else begin
            pgSyncQ[s]  <= pgSyncQ[s-1];
            reqSyncQ[s] <= reqSyncQ[s-1];
          end
        end
      end
    end
  endgenerate

  assign pgSync = pgSyncQ[LastStage];
  assign pgRise = pgSync & ~pgPrev;

  // Start flag and one-time address capture
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      pgPrev  <= 1'b0;
      started <= 1'b0;
      busAddr <= '0;
    end else begin
      pgPrev <= pgSync;
      if (pgRise && !started) begin
        started <= 1'b1;
        busAddr <= decodeAddr(addrSel);
      end
    end
  end

  assign strb.active = started & pgSync;
  assign strb.runReq = reqSyncQ[LastStage];

  AST_START_STICKY: assert property (@(posedge refClk) disable iff (!rstN)
    started |=> started); // R4
  AST_ADDR_HOLD: assert property (@(posedge refClk) disable iff (!rstN)
    $past(started) |-> $stable(busAddr)); // R4
  AST_NO_EARLY_ADDR: assert property (@(posedge refClk) disable iff (!rstN)
    !started |-> (busAddr == '0)); // R1
endmodule

// File: rtl/clkFanPath.sv
module clkFanPath
  import clkfan_pkg::*;
#(
  parameter int NumOut = OUT_COUNT
) (
  input  logic              refClk,
  input  logic              rstN,
  input  gateStrb_t         strb,
  output logic [NumOut-1:0] outTrue,
  output logic [NumOut-1:0] outComp
);
  logic [NumOut-1:0] gateQ;

  genvar i;
  generate
    for (i = 0; i < NumOut; i++) begin : gPair
      // Gate changes on the falling edge, while the clock is low
      always_ff @(negedge refClk or negedge rstN) begin
        if (!rstN) gateQ[i] <= 1'b0;
        else       gateQ[i] <= strb.active & strb.runReq[i];
      end
      assign outTrue[i] = refClk & gateQ[i];
      assign outComp[i] = ~refClk & gateQ[i];
    end
  endgenerate

  AST_DOWN_IDLE: assert property (@(negedge refClk) disable iff (!rstN)
    !strb.active |=> (gateQ == '0)); // R3
  AST_GATE_NEEDS_REQ: assert property (@(negedge refClk) disable iff (!rstN)
    (gateQ & ~$past(strb.runReq)) == '0); // R5
endmodule

// File: rtl/clkFanoutGate.sv
module clkFanoutGate
  import clkfan_pkg::*;
(
  input  logic                 refClk,
  input  logic                 rstN,
  input  logic                 pwrGood,
  input  logic [1:0]           addrSel,
  input  logic [OUT_COUNT-1:0] enPinN,
  input  logic                 cfgWe,
  input  logic [OUT_COUNT-1:0] cfgData,
  output logic [OUT_COUNT-1:0] outTrue,
  output logic [OUT_COUNT-1:0] outComp,
  output logic [ADDR_W-1:0]    busAddr
);
  gateStrb_t strb;

  clkFanCtrl #(.NumOut(OUT_COUNT), .SyncStages(SYNC_STAGES), .AddrW(ADDR_W)) uCtrl (
    .refClk (refClk),
    .rstN   (rstN),
    .pwrGood(pwrGood),
    .addrSel(addrSel),
    .enPinN (enPinN),
    .cfgWe  (cfgWe),
    .cfgData(cfgData),
    .strb   (strb),
    .busAddr(busAddr)
  );

  clkFanPath #(.NumOut(OUT_COUNT)) uPath (
    .refClk (refClk),
    .rstN   (rstN),
    .strb   (strb),
    .outTrue(outTrue),
    .outComp(outComp)
  );
endmodule

// File: tb/tb_clkFanoutGate.sv
`timescale 1ns/1ps
module tb_clkFanoutGate;
  logic refClk = 1'b0;
  logic rstN = 1'b0;
  logic pwrGood = 1'b0;
  logic [1:0] addrSel = 2'b00;
  logic [4:0] enPinN = 5'b00000;
  logic cfgWe = 1'b0;
  logic [4:0] cfgData = 5'b00000;
  logic [4:0] outTrue, outComp;
  logic [6:0] busAddr;

  int nTests = 0;
  int nFail = 0;
  int runtCount = 0;
  bit monOn = 1'b0;
  bit doneFlag = 1'b0;
  logic [4:0] prevTrue = 5'b0;

  clkFanoutGate dut (
    .refClk(refClk), .rstN(rstN), .pwrGood(pwrGood), .addrSel(addrSel),
    .enPinN(enPinN), .cfgWe(cfgWe), .cfgData(cfgData),
    .outTrue(outTrue), .outComp(outComp), .busAddr(busAddr)
  );

  always #2.5 refClk = ~refClk;

  // R9: runt monitor on the true legs
  always @(outTrue) begin
    for (int k = 0; k < 5; k++) begin
      if (monOn && outTrue[k] !== prevTrue[k]) begin
        if (outTrue[k] === 1'b1 && refClk !== 1'b1) runtCount++;
        if (outTrue[k] === 1'b0 && refClk !== 1'b0) runtCount++;
      end
    end
    prevTrue = outTrue;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge refClk);
    #1;
  endtask

  // Sample both phases: high phase true=mask, low phase comp=mask
  task automatic checkRun(input logic [4:0] m, input string req);
    @(posedge refClk); #1;
    chk(outTrue === m && outComp === 5'b0, req, {22'b0, outTrue, outComp}, {22'b0, m, 5'b0});
    @(negedge refClk); #1;
    chk(outTrue === 5'b0 && outComp === m, req, {22'b0, outTrue, outComp}, {22'b0, 5'b0, m});
  endtask

  task automatic doReset();
    monOn = 1'b0;
    rstN = 1'b0;
    pwrGood = 1'b0;
    cfgWe = 1'b0;
    #7;
    rstN = 1'b1;
    cycles(2);
    prevTrue = outTrue;
    monOn = 1'b1;
  endtask

  task automatic writeCfg(input logic [4:0] v);
    cfgData = v;
    cfgWe = 1'b1;
    @(posedge refClk); #1;
    cfgWe = 1'b0;
  endtask

  function automatic logic [6:0] expAddr(input logic [1:0] s);
    case (s)
      2'b00:   return 7'b1101011;
      2'b10:   return 7'b1101101;
      default: return 7'b1101100;
    endcase
  endfunction

  initial begin
    #1000000;
    if (!doneFlag) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    for (int sel = 0; sel < 4; sel++) begin
      doReset();
      enPinN = 5'b00000;
      // R1: nothing runs and no address before first power-good
      addrSel = 2'(3 - sel);
      cycles(4);
      addrSel = 2'(sel);
      chk(busAddr === 7'b0, "R1 addr", {25'b0, busAddr}, 32'b0);
      checkRun(5'b00000, "R1 idle");
      // R2: first assertion latches the address; R8: defaults enabled
      pwrGood = 1'b1;
      cycles(8);
      chk(busAddr === expAddr(2'(sel)), "R2 addr", {25'b0, busAddr}, {25'b0, expAddr(2'(sel))});
      checkRun(5'b11111, "R8 default enables");
      checkRun(5'b11111, "R7 complement");
      // R3: power-down; R4: no re-sample
      addrSel = 2'(sel + 1);
      pwrGood = 1'b0;
      cycles(8);
      checkRun(5'b00000, "R3 power-down");
      pwrGood = 1'b1;
      cycles(8);
      checkRun(5'b11111, "R3 exit power-down");
      chk(busAddr === expAddr(2'(sel)), "R4 addr kept", {25'b0, busAddr}, {25'b0, expAddr(2'(sel))});
    end

    // R5/R6: full truth table of enable bits against pins
    for (int r = 0; r < 32; r++) begin
      writeCfg(5'(r));
      for (int p = 0; p < 32; p++) begin
        enPinN = 5'(p);
        cycles(5);
        checkRun(5'(r) & ~5'(p), (5'(r) & 5'(p)) != 0 ? "R6 pin disable" : "R5 enable table");
      end
    end

    // R3 again mid-sweep config, with partial enables
    writeCfg(5'b10101);
    enPinN = 5'b00100;
    cycles(5);
    pwrGood = 1'b0;
    cycles(6);
    checkRun(5'b00000, "R3 power-down partial");
    pwrGood = 1'b1;
    cycles(6);
    checkRun(5'b10001, "R3 resume partial");

    // R9: no runt pulse seen on any transition
    chk(runtCount == 0, "R9 runt pulses", 32'(runtCount), 32'b0);

    doneFlag = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule